// File: doc/BRIEF.md
# Ethernet receive address filter

This block decides whether an incoming Ethernet frame is kept. It watches the first six bytes of the frame, which are the destination address, one byte per clock. One clock after the sixth byte it issues a single verdict: accept or reject, and a group flag for accepted broadcast and multicast frames. The decision uses the frame length given at frame start, a programmable minimum length, three mode inputs (promiscuous, broadcast disable, multicast enable), a 48-bit station address register, and a 64-bit multicast hash table.

The hash table is loaded from a byte stream of 6-byte group addresses. A load request gives the byte count of the list. The block then clears the table, takes at most 64 whole addresses while it raises `ml_ready`, and sets one table bit for each address. The table and the frame path share one CRC-32 engine, so a load and a frame decision never run at the same time. A load request made during a frame waits for that frame's decision. A frame that starts while a load is running is rejected.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `dec_valid` and `ml_ready` are low and every hash-table bit is clear, so a multicast frame is rejected even with `cfg_mcast_en` high.
- R2: Destination bytes are the cycles with `fr_valid` high; the first is the one with `fr_start` high, and the first byte is the most significant byte of a 48-bit address. `dec_valid` is high for exactly the one cycle after the sixth byte, and `dec_accept`/`dec_group` are low whenever `dec_valid` is low.
- R3: A frame whose `fr_len` (latched at its start) is below max(`cfg_min_len`, 5) is rejected in every mode.
- R4: With `cfg_promisc` high, every frame that is long enough is accepted with `dec_group` low.
- R5: An all-ones destination is rejected when `cfg_bcast_dis` is high, otherwise it is accepted with `dec_group` high.
- R6: A destination whose first byte has bit 0 set (and that is not all ones) is accepted, with `dec_group` high, only if `cfg_mcast_en` is high and its hash bit is set; otherwise it is rejected.
- R7: Any other destination is accepted, with `dec_group` low, only if all 48 bits equal the station address written through `ua_wr`/`ua_data`.
- R8: Every load first clears all 64 hash bits, even when the list holds no whole address.
- R9: A load takes floor(`ml_len` / 6) addresses, capped at 64; `ml_ready` falls after the last byte of the last taken address, and bytes offered beyond it are not taken.
- R10: The hash index is bits 7..2 of a CRC-32 over the six address bytes: register preset to all ones, bytes taken first to last, each byte least significant bit first, each step shifts left and XORs 0x04C11DB7 when (old bit 31 XOR data bit) is 1, no final inversion. Distinct addresses with equal index share one bit.
- R11: A load request made while a frame is being collected waits: `ml_ready` stays low through the decision cycle and rises in the cycle after it.
- R12: An `fr_start` during an unfinished destination restarts collection; only the new frame produces a decision.
- R13: A frame that starts while a load is running (or starting) is rejected; the load is unaffected and completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_promisc | input | 1 | Accept all destinations |
| cfg_bcast_dis | input | 1 | Reject all-ones destinations |
| cfg_mcast_en | input | 1 | Allow hashed multicast acceptance |
| cfg_min_len | input | 16 | Minimum frame length in bytes (floor 5) |
| ua_wr | input | 1 | Write strobe for the station address |
| ua_data | input | 48 | Station address, first wire byte in bits 47..40 |
| ml_req | input | 1 | Request to load a multicast list |
| ml_len | input | 16 | Byte count of the list, sampled with `ml_req` |
| ml_valid | input | 1 | List byte present |
| ml_byte | input | 8 | List byte |
| ml_ready | output | 1 | High while list bytes are taken |
| fr_start | input | 1 | Marks the first destination byte |
| fr_valid | input | 1 | Destination byte present |
| fr_byte | input | 8 | Destination byte |
| fr_len | input | 16 | Frame length, sampled with `fr_start` |
| dec_valid | output | 1 | Verdict strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_group | output | 1 | Accepted frame was broadcast or multicast |

## Verification
On every cycle the assertions check the shape of the verdict: it is a single-cycle pulse that follows a valid byte, a group flag only comes with an accept, and promiscuous or short frames never produce a flag or an accept. They also check that the loader and the frame path never both drive the shared CRC engine, that a load begins only after any frame has finished, and that the table is empty when a load begins. The address classes, the hash index, the entry cap and the outcome of the load/frame collisions depend on data values and orderings, so only the bench's scenarios can show them: it computes expected hash indices on its own, finds colliding and non-colliding addresses, and counts taken list bytes.

// File: rtl/rxf_pkg.sv
// Package for the receive address filter.
// Holds the CRC constants, the verdict type and the one-byte CRC step.
// Assumes bytes enter the CRC least significant bit first.
package rxf_pkg;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef struct packed {
        logic accept;
        logic group;
    } verdict_t;

    // Advance a left-shifting CRC-32 register by one byte, LSB of the byte first.
    function automatic logic [31:0] crc_step(input logic [31:0] crc_in,
                                             input logic [7:0]  data);
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            fb = c[31] ^ data[b];
            c  = {c[30:0], 1'b0};
            if (fb) begin
                c = c ^ CRC_POLY;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/rxf_crc_unit.sv
// Byte-serial CRC-32 engine shared by the loader and the frame path.
// Each enabled cycle folds one byte in; 'start' restarts from the seed.
// Presents the tap slice of the updated value in the same cycle.
// Assumes at most one client enables it in any cycle.
module rxf_crc_unit #(
    parameter int TAP_LSB = 2,
    parameter int TAP_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             en,
    input  logic [7:0]       data,
    output logic [TAP_W-1:0] tap
);
    import rxf_pkg::*;

    logic [31:0] crc_q;
    logic [31:0] crc_nxt;

    // Next CRC value from the seed or the running value.
    always_comb begin
        crc_nxt = crc_step(start ? CRC_SEED : crc_q, data);
    end

    assign tap = crc_nxt[TAP_LSB +: TAP_W];

    // Hold the running CRC between bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (en) begin
            crc_q <= crc_nxt;
        end
    end

endmodule

// File: rtl/rxf_hash_loader.sv
// Multicast hash table and its list loader.
// A request latches the list byte count; the load begins once no frame
// is being collected, clears the table, then takes whole addresses
// (count / ADDR_BYTES, capped at MAX_ENTRIES) and sets one bit each.
// Requests while a load is pending or running are ignored.
module rxf_hash_loader #(
    parameter int LEN_W       = 16,
    parameter int HASH_W      = 6,
    parameter int MAX_ENTRIES = 64,
    parameter int ADDR_BYTES  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic [LEN_W-1:0]     req_len,
    input  logic                 frame_busy,
    input  logic                 byte_valid,
    input  logic [7:0]           byte_data,
    input  logic [HASH_W-1:0]    hash_idx,
    output logic                 ready,
    output logic                 busy,
    output logic                 crc_start,
    output logic                 crc_en,
    output logic [7:0]           crc_data,
    output logic [(1<<HASH_W)-1:0] hash_tbl
);
    localparam int ENT_W = $clog2(MAX_ENTRIES + 1);
    localparam int IDX_W = $clog2(ADDR_BYTES);
    localparam int TBL_N = 1 << HASH_W;

    logic              pend_q;
    logic [LEN_W-1:0]  pend_len_q;
    logic              active_q;
    logic [ENT_W-1:0]  left_q;
    logic [IDX_W-1:0]  idx_q;
    logic [TBL_N-1:0]  tbl_q;

    logic [LEN_W-1:0]  entries_raw;
    logic [ENT_W-1:0]  entries;
    logic              go;
    logic              take;
    logic              addr_done;

    // Number of whole addresses in the pending list, capped.
    always_comb begin
        entries_raw = pend_len_q / LEN_W'(ADDR_BYTES);
        if (entries_raw > LEN_W'(MAX_ENTRIES)) begin
            entries = ENT_W'(MAX_ENTRIES);
        end else begin
            entries = ENT_W'(entries_raw);
        end
    end

    assign go        = pend_q && !active_q && !frame_busy;
    assign take      = active_q && byte_valid;
    assign addr_done = take && (idx_q == IDX_W'(ADDR_BYTES - 1));

    assign crc_start = take && (idx_q == '0);
    assign crc_en    = take;
    assign crc_data  = byte_data;
    assign ready     = active_q;
    assign busy      = active_q || go;
    assign hash_tbl  = tbl_q;

    // Latch a request until the load can begin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_len_q <= '0;
        end else if (go) begin
            pend_q     <= 1'b0;
        end else if (req && !pend_q && !active_q) begin
            pend_q     <= 1'b1;
            pend_len_q <= req_len;
        end
    end

    // Walk through the list address by address, byte by byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            left_q   <= '0;
            idx_q    <= '0;
        end else if (go) begin
            active_q <= (entries != '0);
            left_q   <= entries;
            idx_q    <= '0;
        end else if (take) begin
            if (addr_done) begin
                idx_q  <= '0;
                left_q <= left_q - ENT_W'(1);
                if (left_q == ENT_W'(1)) begin
                    active_q <= 1'b0;
                end
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // Clear the table at load start, set one bit per finished address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else if (go) begin
            tbl_q <= '0;
        end else if (addr_done) begin
            tbl_q[hash_idx] <= 1'b1;
        end
    end

endmodule

// File: rtl/rxf_frame_decider.sv
// Destination collector and verdict logic.
// Collects ADDR_BYTES destination bytes after a frame start, then
// registers one verdict from length, mode inputs, station address and
// hash table. A frame started while the loader is busy is rejected and
// leaves the shared CRC engine to the loader.
module rxf_frame_decider #(
    parameter int LEN_W      = 16,
    parameter int HASH_W     = 6,
    parameter int ADDR_BYTES = 6,
    parameter int MIN_FLOOR  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fr_start,
    input  logic                    fr_valid,
    input  logic [7:0]              fr_byte,
    input  logic [LEN_W-1:0]        fr_len,
    input  logic                    cfg_promisc,
    input  logic                    cfg_bcast_dis,
    input  logic                    cfg_mcast_en,
    input  logic [LEN_W-1:0]        cfg_min_len,
    input  logic [8*ADDR_BYTES-1:0] station,
    input  logic [(1<<HASH_W)-1:0]  hash_tbl,
    input  logic [HASH_W-1:0]       hash_idx,
    input  logic                    load_busy,
    output logic                    crc_start,
    output logic                    crc_en,
    output logic [7:0]              crc_data,
    output logic                    collecting,
    output logic                    dec_valid,
    output logic                    dec_accept,
    output logic                    dec_group
);
    import rxf_pkg::*;

    localparam int DST_W = 8 * ADDR_BYTES;
    localparam int CNT_W = $clog2(ADDR_BYTES);

    logic              coll_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DST_W-9:0]  dst_q;
    logic              short_q;
    logic              blocked_q;
    logic              dv_q;
    verdict_t          verd_q;

    logic              first;
    logic              take;
    logic [CNT_W-1:0]  cur_cnt;
    logic              last;
    logic              cur_blocked;
    logic [DST_W-1:0]  full_dst;
    logic [LEN_W-1:0]  eff_min;
    verdict_t          verd;

    assign first       = fr_start && fr_valid;
    assign take        = fr_valid && (first || coll_q);
    assign cur_cnt     = first ? '0 : cnt_q;
    assign last        = take && (cur_cnt == CNT_W'(ADDR_BYTES - 1));
    assign cur_blocked = first ? load_busy : blocked_q;
    assign full_dst    = {dst_q, fr_byte};
    assign eff_min     = (cfg_min_len < LEN_W'(MIN_FLOOR)) ? LEN_W'(MIN_FLOOR) : cfg_min_len;

    assign crc_start   = first;
    assign crc_en      = take && !cur_blocked;
    assign crc_data    = fr_byte;
    assign collecting  = coll_q;

    // Classify the completed destination and pick the verdict.
    always_comb begin
        verd.accept = 1'b0;
        verd.group  = 1'b0;
        if (blocked_q || short_q) begin
            verd.accept = 1'b0;
        end else if (cfg_promisc) begin
            verd.accept = 1'b1;
        end else if (&full_dst) begin
            verd.accept = !cfg_bcast_dis;
            verd.group  = !cfg_bcast_dis;
        end else if (full_dst[DST_W-8]) begin
            verd.accept = cfg_mcast_en && hash_tbl[hash_idx];
            verd.group  = cfg_mcast_en && hash_tbl[hash_idx];
        end else begin
            verd.accept = (full_dst == station);
        end
    end

    // Track the collection window and the byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coll_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (last) begin
                coll_q <= 1'b0;
            end else if (first) begin
                coll_q <= 1'b1;
            end
            if (take) begin
                cnt_q <= cur_cnt + CNT_W'(1);
            end
        end
    end

    // Shift in destination bytes and latch per-frame qualifiers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q     <= '0;
            short_q   <= 1'b0;
            blocked_q <= 1'b0;
        end else begin
            if (first) begin
                dst_q     <= {{(DST_W-16){1'b0}}, fr_byte};
                short_q   <= (fr_len < eff_min);
                blocked_q <= load_busy;
            end else if (take) begin
                dst_q     <= {dst_q[DST_W-17:0], fr_byte};
            end
        end
    end

    // Register the one-cycle verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_q   <= 1'b0;
            verd_q <= '0;
        end else begin
            dv_q   <= last;
            verd_q <= last ? verd : '0;
        end
    end

    assign dec_valid  = dv_q;
    assign dec_accept = verd_q.accept;
    assign dec_group  = verd_q.group;

endmodule

// File: rtl/rx_addr_filter.sv
// Top of the receive address filter.
// Holds the station address, and joins the frame decider, the hash
// loader and the shared CRC engine. The CRC engine is driven by the
// loader while it takes list bytes, otherwise by the frame path.
module rx_addr_filter #(
    parameter int LEN_W       = 16,
    parameter int HASH_W      = 6,
    parameter int HASH_LSB    = 2,
    parameter int MAX_ENTRIES = 64,
    parameter int ADDR_BYTES  = 6,
    parameter int MIN_FLOOR   = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_promisc,
    input  logic                    cfg_bcast_dis,
    input  logic                    cfg_mcast_en,
    input  logic [LEN_W-1:0]        cfg_min_len,
    input  logic                    ua_wr,
    input  logic [8*ADDR_BYTES-1:0] ua_data,
    input  logic                    ml_req,
    input  logic [LEN_W-1:0]        ml_len,
    input  logic                    ml_valid,
    input  logic [7:0]              ml_byte,
    output logic                    ml_ready,
    input  logic                    fr_start,
    input  logic                    fr_valid,
    input  logic [7:0]              fr_byte,
    input  logic [LEN_W-1:0]        fr_len,
    output logic                    dec_valid,
    output logic                    dec_accept,
    output logic                    dec_group
);
    localparam int TBL_N = 1 << HASH_W;

    logic [8*ADDR_BYTES-1:0] station_q;
    logic [TBL_N-1:0]        hash_tbl;
    logic [HASH_W-1:0]       hash_idx;
    logic                    frame_busy;
    logic                    load_busy;

    logic                    ld_crc_start, ld_crc_en;
    logic [7:0]              ld_crc_data;
    logic                    fr_crc_start, fr_crc_en;
    logic [7:0]              fr_crc_data;

    // Station address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            station_q <= '0;
        end else if (ua_wr) begin
            station_q <= ua_data;
        end
    end

    rxf_crc_unit #(
        .TAP_LSB (HASH_LSB),
        .TAP_W   (HASH_W)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ld_crc_en ? ld_crc_start : fr_crc_start),
        .en    (ld_crc_en | fr_crc_en),
        .data  (ld_crc_en ? ld_crc_data : fr_crc_data),
        .tap   (hash_idx)
    );

    rxf_hash_loader #(
        .LEN_W       (LEN_W),
        .HASH_W      (HASH_W),
        .MAX_ENTRIES (MAX_ENTRIES),
        .ADDR_BYTES  (ADDR_BYTES)
    ) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (ml_req),
        .req_len    (ml_len),
        .frame_busy (frame_busy),
        .byte_valid (ml_valid),
        .byte_data  (ml_byte),
        .hash_idx   (hash_idx),
        .ready      (ml_ready),
        .busy       (load_busy),
        .crc_start  (ld_crc_start),
        .crc_en     (ld_crc_en),
        .crc_data   (ld_crc_data),
        .hash_tbl   (hash_tbl)
    );

    rxf_frame_decider #(
        .LEN_W      (LEN_W),
        .HASH_W     (HASH_W),
        .ADDR_BYTES (ADDR_BYTES),
        .MIN_FLOOR  (MIN_FLOOR)
    ) u_decider (
        .clk           (clk),
        .rst_n         (rst_n),
        .fr_start      (fr_start),
        .fr_valid      (fr_valid),
        .fr_byte       (fr_byte),
        .fr_len        (fr_len),
        .cfg_promisc   (cfg_promisc),
        .cfg_bcast_dis (cfg_bcast_dis),
        .cfg_mcast_en  (cfg_mcast_en),
        .cfg_min_len   (cfg_min_len),
        .station       (station_q),
        .hash_tbl      (hash_tbl),
        .hash_idx      (hash_idx),
        .load_busy     (load_busy),
        .crc_start     (fr_crc_start),
        .crc_en        (fr_crc_en),
        .crc_data      (fr_crc_data),
        .collecting    (frame_busy),
        .dec_valid     (dec_valid),
        .dec_accept    (dec_accept),
        .dec_group     (dec_group)
    );

endmodule

// File: rtl/rx_addr_filter_chk.sv
// Checker for rx_addr_filter, attached by bind.
// Watches the verdict outputs, the CRC ownership and the load start.
// Keeps one flag of its own: whether the current frame is too short.
module rx_addr_filter_chk #(
    parameter int LEN_W     = 16,
    parameter int TBL_N     = 64,
    parameter int MIN_FLOOR = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fr_start,
    input  logic             fr_valid,
    input  logic [LEN_W-1:0] fr_len,
    input  logic [LEN_W-1:0] cfg_min_len,
    input  logic             cfg_promisc,
    input  logic             dec_valid,
    input  logic             dec_accept,
    input  logic             dec_group,
    input  logic             ml_ready,
    input  logic             collecting,
    input  logic             ld_crc_en,
    input  logic             fr_crc_en,
    input  logic [TBL_N-1:0] hash_tbl
);
    logic chk_short;

    // Remember whether the frame in progress falls under the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_short <= 1'b0;
        end else if (fr_start && fr_valid) begin
            chk_short <= (fr_len < LEN_W'(MIN_FLOOR)) || (fr_len < cfg_min_len);
        end
    end

    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    p_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(fr_valid));

    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_accept && !dec_group));

    p_short_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && chk_short) |-> !dec_accept);

    p_promisc_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(cfg_promisc)) |-> !dec_group);

    p_group_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_group) |-> dec_accept);

    p_table_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ml_ready) |-> (hash_tbl == '0));

    p_load_after_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ml_ready) |-> !$past(collecting));

    p_crc_owner_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_crc_en, fr_crc_en}));

endmodule

bind rx_addr_filter rx_addr_filter_chk #(
    .LEN_W     (LEN_W),
    .TBL_N     (1 << HASH_W),
    .MIN_FLOOR (MIN_FLOOR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fr_start    (fr_start),
    .fr_valid    (fr_valid),
    .fr_len      (fr_len),
    .cfg_min_len (cfg_min_len),
    .cfg_promisc (cfg_promisc),
    .dec_valid   (dec_valid),
    .dec_accept  (dec_accept),
    .dec_group   (dec_group),
    .ml_ready    (ml_ready),
    .collecting  (frame_busy),
    .ld_crc_en   (ld_crc_en),
    .fr_crc_en   (fr_crc_en),
    .hash_tbl    (hash_tbl)
);

// File: tb/rx_addr_filter_tb.sv
// Directed bench for rx_addr_filter: one task per scenario.
module rx_addr_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] UA = 48'h02AB_CDEF_0123;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_promisc = 1'b0, cfg_bcast_dis = 1'b0, cfg_mcast_en = 1'b0;
    logic [15:0] cfg_min_len = '0;
    logic        ua_wr = 1'b0;
    logic [47:0] ua_data = '0;
    logic        ml_req = 1'b0, ml_valid = 1'b0;
    logic [15:0] ml_len = '0;
    logic [7:0]  ml_byte = '0;
    logic        ml_ready;
    logic        fr_start = 1'b0, fr_valid = 1'b0;
    logic [7:0]  fr_byte = '0;
    logic [15:0] fr_len = '0;
    logic        dec_valid, dec_accept, dec_group;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [47:0] mlist [0:69];
    logic [47:0] addr_a, addr_b, addr_c, addr_d;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_promisc(cfg_promisc), .cfg_bcast_dis(cfg_bcast_dis),
        .cfg_mcast_en(cfg_mcast_en), .cfg_min_len(cfg_min_len),
        .ua_wr(ua_wr), .ua_data(ua_data),
        .ml_req(ml_req), .ml_len(ml_len), .ml_valid(ml_valid),
        .ml_byte(ml_byte), .ml_ready(ml_ready),
        .fr_start(fr_start), .fr_valid(fr_valid), .fr_byte(fr_byte),
        .fr_len(fr_len),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_group(dec_group)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Hash index computed from the requirement's CRC definition.
    function automatic logic [5:0] bhash(input logic [47:0] a);
        logic [31:0] c;
        logic fb;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            for (int b = 0; b < 8; b++) begin
                fb = c[31] ^ a[40 - 8*k + b];
                c = c << 1;
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        end
        return c[7:2];
    endfunction

    // Send a destination, check silence until the verdict and the verdict itself.
    task automatic send_frame(input logic [47:0] d, input logic [15:0] len, input int gap,
                              input logic exp_acc, input logic exp_grp, input string tag);
        @(negedge clk);
        fr_valid = 1'b1; fr_start = 1'b1; fr_byte = d[47:40]; fr_len = len;
        for (int i = 1; i < 6; i++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                fr_valid = 1'b0; fr_start = 1'b0;
                chk({tag, " R2 quiet"}, dec_valid, 1'b0);
            end
            @(negedge clk);
            chk({tag, " R2 quiet"}, dec_valid, 1'b0);
            fr_valid = 1'b1; fr_start = 1'b0; fr_byte = d[47 - 8*i -: 8];
        end
        @(negedge clk);
        fr_valid = 1'b0; fr_start = 1'b0;
        chk({tag, " R2 valid"}, dec_valid, 1'b1);
        chk({tag, " accept"}, dec_accept, exp_acc);
        chk({tag, " group"}, dec_group, exp_grp);
        @(negedge clk);
        chk({tag, " R2 pulse end"}, dec_valid, 1'b0);
    endtask

    // Offer list bytes while ml_ready is high; report bytes taken and wait cycles.
    task automatic feed(input int nsend, output int taken, output int lat);
        bit seen;
        int idle;
        seen = 1'b0; taken = 0; lat = 0; idle = 0;
        forever begin
            @(negedge clk);
            ml_req = 1'b0;
            if (ml_ready) begin
                seen = 1'b1;
                if (taken < nsend) begin
                    ml_valid = 1'b1;
                    ml_byte = mlist[taken / 6][47 - 8*(taken % 6) -: 8];
                    taken++;
                end else begin
                    ml_valid = 1'b0;
                end
            end else begin
                ml_valid = 1'b0;
                if (seen) break;
                lat++;
                idle++;
                if (idle > 20) break;
            end
        end
    endtask

    task automatic load_list(input int count, input int nsend, output int taken);
        int lat;
        @(negedge clk);
        ml_req = 1'b1; ml_len = 16'(count);
        feed(nsend, taken, lat);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 dec_valid", dec_valid, 1'b0);
        chk("R1 ml_ready", ml_ready, 1'b0);
        @(negedge clk);
        ua_wr = 1'b1; ua_data = UA;
        @(negedge clk);
        ua_wr = 1'b0;
    endtask

    task automatic t_unicast();
        send_frame(UA, 64, 0, 1'b1, 1'b0, "R7 match");
        send_frame(UA ^ 48'h1, 64, 0, 1'b0, 1'b0, "R7 last bit");
        send_frame(UA ^ 48'h0400_0000_0000, 64, 0, 1'b0, 1'b0, "R7 first byte");
        send_frame(UA, 64, 2, 1'b1, 1'b0, "R2 gaps");
    endtask

    task automatic t_restart();
        @(negedge clk);
        fr_valid = 1'b1; fr_start = 1'b1; fr_byte = 8'hFF; fr_len = 64;
        @(negedge clk);
        fr_start = 1'b0; fr_byte = 8'hFF;
        @(negedge clk);
        fr_byte = 8'hFF;
        send_frame(UA, 64, 0, 1'b1, 1'b0, "R12 restart");
    endtask

    task automatic t_bcast();
        cfg_bcast_dis = 1'b0;
        send_frame('1, 64, 0, 1'b1, 1'b1, "R5 allowed");
        cfg_bcast_dis = 1'b1;
        send_frame('1, 64, 0, 1'b0, 1'b0, "R5 disabled");
        cfg_bcast_dis = 1'b0;
    endtask

    task automatic t_promisc();
        cfg_promisc = 1'b1; cfg_bcast_dis = 1'b1;
        send_frame('1, 64, 0, 1'b1, 1'b0, "R4 bcast");
        send_frame(48'h0412_3456_789A, 64, 0, 1'b1, 1'b0, "R4 other");
        send_frame(48'h0100_5E00_0099, 64, 0, 1'b1, 1'b0, "R4 mcast");
        send_frame(UA, 4, 0, 1'b0, 1'b0, "R3 promisc short");
        cfg_promisc = 1'b0; cfg_bcast_dis = 1'b0;
    endtask

    task automatic t_length();
        cfg_min_len = 60;
        send_frame(UA, 59, 0, 1'b0, 1'b0, "R3 below");
        send_frame(UA, 60, 0, 1'b1, 1'b0, "R3 equal");
        cfg_min_len = 2;
        send_frame(UA, 4, 0, 1'b0, 1'b0, "R3 floor");
        send_frame(UA, 5, 0, 1'b1, 1'b0, "R3 floor ok");
        cfg_min_len = 0;
    endtask

    task automatic t_mcast();
        int taken;
        cfg_mcast_en = 1'b1;
        send_frame(addr_a, 64, 0, 1'b0, 1'b0, "R1 empty table");
        mlist[0] = addr_a; mlist[1] = addr_b;
        load_list(12, 12, taken);
        chk("R9 two entries", taken, 12);
        send_frame(addr_a, 64, 0, 1'b1, 1'b1, "R6 hit A");
        send_frame(addr_b, 64, 0, 1'b1, 1'b1, "R6 hit B");
        send_frame(addr_c, 64, 0, 1'b0, 1'b0, "R10 miss");
        send_frame(addr_d, 64, 0, 1'b1, 1'b1, "R10 collision");
        cfg_mcast_en = 1'b0;
        send_frame(addr_a, 64, 0, 1'b0, 1'b0, "R6 disabled");
        cfg_mcast_en = 1'b1;
        mlist[0] = addr_c;
        load_list(6, 6, taken);
        send_frame(addr_c, 64, 0, 1'b1, 1'b1, "R8 new entry");
        send_frame(addr_a, 64, 0, 1'b0, 1'b0, "R8 old cleared");
    endtask

    task automatic t_capacity();
        int taken;
        for (int i = 0; i < 70; i++) mlist[i] = {24'h01005E, 16'h2000, 8'(i)};
        mlist[2] = addr_a;
        load_list(20, 30, taken);
        chk("R9 floor of count/6", taken, 18);
        send_frame(addr_a, 64, 0, 1'b1, 1'b1, "R9 third entry");
        load_list(390, 400, taken);
        chk("R9 cap at 64", taken, 384);
        load_list(5, 5, taken);
        chk("R9 no whole entry", taken, 0);
        send_frame(addr_a, 64, 0, 1'b0, 1'b0, "R8 clear on empty list");
    endtask

    task automatic t_wait();
        int taken, lat;
        mlist[0] = addr_b;
        @(negedge clk);
        fr_valid = 1'b1; fr_start = 1'b1; fr_byte = UA[47:40]; fr_len = 64;
        for (int i = 1; i < 6; i++) begin
            @(negedge clk);
            if (i == 2) begin
                ml_req = 1'b1; ml_len = 6;
            end else begin
                ml_req = 1'b0;
            end
            if (i > 2) chk("R11 held off", ml_ready, 1'b0);
            fr_start = 1'b0; fr_byte = UA[47 - 8*i -: 8];
        end
        @(negedge clk);
        fr_valid = 1'b0;
        chk("R11 verdict", dec_valid, 1'b1);
        chk("R11 verdict accept", dec_accept, 1'b1);
        chk("R11 not in decision cycle", ml_ready, 1'b0);
        feed(6, taken, lat);
        chk("R11 ready next cycle", lat, 0);
        chk("R11 bytes", taken, 6);
        send_frame(addr_b, 64, 0, 1'b1, 1'b1, "R11 loaded");
    endtask

    task automatic t_block();
        int taken, lat;
        mlist[0] = addr_a;
        @(negedge clk);
        ml_req = 1'b1; ml_len = 6;
        @(negedge clk);
        ml_req = 1'b0;
        @(negedge clk);
        chk("R13 load running", ml_ready, 1'b1);
        send_frame(UA, 64, 0, 1'b0, 1'b0, "R13 frame during load");
        chk("R13 load still running", ml_ready, 1'b1);
        feed(6, taken, lat);
        chk("R13 load bytes", taken, 6);
        send_frame(addr_a, 64, 0, 1'b1, 1'b1, "R13 load intact");
        send_frame(UA, 64, 0, 1'b1, 1'b0, "R13 after load");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        addr_a = 48'h0100_5E00_0001;
        addr_b = 48'h3333_0000_0001;
        addr_c = 48'h0100_5E00_1000;
        for (int i = 0; i < 65536; i++) begin
            addr_c = {32'h0100_5E01, 16'(i)};
            if (bhash(addr_c) != bhash(addr_a) && bhash(addr_c) != bhash(addr_b)) break;
        end
        addr_d = addr_a;
        for (int i = 1; i < 65536; i++) begin
            addr_d = {32'h0100_5E02, 16'(i)};
            if (bhash(addr_d) == bhash(addr_a)) break;
        end
        for (int i = 0; i < 70; i++) mlist[i] = '0;
        t_reset();
        t_unicast();
        t_restart();
        t_bcast();
        t_promisc();
        t_length();
        t_mcast();
        t_capacity();
        t_wait();
        t_block();
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule